// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the two error counters that set a CAN node's fault confinement state. A protocol engine reports what happened on the bus through one-cycle strobes. These cover ordinary and severe receive errors, successful receptions, transmit errors, successful transmissions, and detected recessive-idle sequences. The block turns those strobes into counter updates and a three-way state: error active, error passive or bus-off.

The transmit counter is 9 bits wide internally, but only its low byte leaves the block. The receive counter is 8 bits wide and saturates. A successful reception pulls a high receive count straight down to 120 rather than decrementing it. A node in bus-off ignores all traffic events. It returns only after 128 recessive-idle sequences, which clear both counters. Both counters are read-only: nothing outside the block can load them.

Top module: `can_fault_counters`

## Requirements
- R1: After reset both counter outputs read 0 and `node_state` reads 0 (error active).
- R2: Outside bus-off, a transmit error adds 8 to the 9-bit transmit counter. A successful transmission subtracts 1, but a counter at 0 stays at 0. `tx_count_lo` always shows bits 7:0 of that counter.
- R3: Outside bus-off, a receive error adds 1 to the receive counter. A severe receive error adds 8 instead, and a strobe on both receive error inputs in one cycle counts as severe.
- R4: Outside bus-off, a successful reception with no receive error in the same cycle changes the receive counter as follows: above 128 it becomes 120, from 1 to 128 it drops by 1, and at 0 it stays 0.
- R5: An increment that would pass 255 leaves the receive counter at 255.
- R6: `node_state` reads 1 (error passive) when either counter exceeds 127 and the node is not bus-off. It reads 0 when both counters are at or below 127.
- R7: In the cycle after an update takes the transmit counter above 255, `node_state` reads 2 (bus-off). Outside bus-off the transmit counter never exceeds 255.
- R8: While bus-off, receive and transmit error and success strobes have no effect, and both counters hold their values.
- R9: While bus-off, the 128th recessive-idle strobe clears both counters and returns `node_state` to 0 in the next cycle. Outside bus-off, recessive-idle strobes have no effect.
- R10: When an error strobe and a success strobe for the same counter arrive in one cycle, only the error is applied. Strobes for different counters in one cycle are all applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rx_err | input | 1 | Ordinary receive error strobe |
| ev_rx_err_severe | input | 1 | Severe receive error strobe |
| ev_rx_ok | input | 1 | Successful reception strobe |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_tx_ok | input | 1 | Successful transmission strobe |
| ev_idle_seq | input | 1 | Recessive-idle sequence detected strobe |
| tx_count_lo | output | 8 | Low byte of the transmit error counter |
| rx_count | output | 8 | Receive error counter |
| node_state | output | 2 | 0 error active, 1 error passive, 2 bus-off |

## Verification
The hardest point to reach from the ports is bus-off recovery. The transmit counter has to be driven past 255 while successes pull it back down. After that, exactly 128 idle strobes must arrive while every other strobe is ignored. Directed runs first cover the boundaries exactly: 248 versus 256 on transmit, 128 versus 129 on receive, and the 127th versus the 128th idle strobe. Random phases then change the strobe weights. Transmit-error-heavy phases push the node into bus-off, and idle-heavy phases bring it back, several times over. A bench model checks every output after every cycle.

// File: rtl/can_fault_counters.sv
module can_fault_counters #(
  parameter int TX_W            = 9,
  parameter int RX_W            = 8,
  parameter int TX_ERR_STEP     = 8,
  parameter int RX_SEVERE_STEP  = 8,
  parameter int PASSIVE_LIMIT   = 127,
  parameter int RX_RELOAD_ABOVE = 128,
  parameter int RX_RELOAD_VALUE = 120,
  parameter int RECOVERY_SEQS   = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_rx_err,
  input  logic       ev_rx_err_severe,
  input  logic       ev_rx_ok,
  input  logic       ev_tx_err,
  input  logic       ev_tx_ok,
  input  logic       ev_idle_seq,
  output logic [7:0] tx_count_lo,
  output logic [7:0] rx_count,
  output logic [1:0] node_state
);
  localparam int BUSOFF_LIMIT = (1 << (TX_W - 1)) - 1;
  localparam int RX_MAX       = (1 << RX_W) - 1;
  localparam int REC_W        = $clog2(RECOVERY_SEQS);

  logic [TX_W-1:0]  tx_q, tx_d;
  logic [RX_W-1:0]  rx_q, rx_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             busoff_q, busoff_d;
  logic [RX_W:0]    rx_sum;
  logic             rx_err_any, passive;

  assign rx_err_any = ev_rx_err | ev_rx_err_severe;
  assign rx_sum = {1'b0, rx_q} + (ev_rx_err_severe ? (RX_W+1)'(RX_SEVERE_STEP) : (RX_W+1)'(1));

  always_comb begin
    tx_d     = tx_q;
    rx_d     = rx_q;
    rec_d    = rec_q;
    busoff_d = busoff_q;
    if (busoff_q) begin
      if (ev_idle_seq) begin
        if (rec_q == REC_W'(RECOVERY_SEQS - 1)) begin
          tx_d     = '0;
          rx_d     = '0;
          rec_d    = '0;
          busoff_d = 1'b0;
        end else begin
          rec_d = rec_q + 1'b1;
        end
      end
    end else begin
      if (ev_tx_err)
        tx_d = tx_q + TX_W'(TX_ERR_STEP);
      else if (ev_tx_ok && tx_q != '0)
        tx_d = tx_q - 1'b1;

      if (rx_err_any)
        rx_d = rx_sum[RX_W] ? RX_W'(RX_MAX) : rx_sum[RX_W-1:0];
      else if (ev_rx_ok) begin
        if (rx_q > RX_W'(RX_RELOAD_ABOVE))
          rx_d = RX_W'(RX_RELOAD_VALUE);
        else if (rx_q != '0)
          rx_d = rx_q - 1'b1;
      end

      busoff_d = tx_d > TX_W'(BUSOFF_LIMIT);
      rec_d    = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      rec_q    <= '0;
      busoff_q <= 1'b0;
    end else begin
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      rec_q    <= rec_d;
      busoff_q <= busoff_d;
    end
  end

  assign passive     = (tx_q > TX_W'(PASSIVE_LIMIT)) || (rx_q > RX_W'(PASSIVE_LIMIT));
  assign tx_count_lo = tx_q[7:0];
  assign rx_count    = rx_q;
  assign node_state  = busoff_q ? 2'd2 : (passive ? 2'd1 : 2'd0);

  AST_RX_SEVERE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state != 2'd2 && ev_rx_err_severe && rx_q <= RX_W'(RX_MAX - RX_SEVERE_STEP))
    |=> rx_count == $past(rx_count) + 8'(RX_SEVERE_STEP)); // R3

  AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state != 2'd2 && ev_rx_ok && !rx_err_any && rx_count > 8'(RX_RELOAD_ABOVE))
    |=> rx_count == 8'(RX_RELOAD_VALUE)); // R4

  AST_PASSIVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    node_state == 2'd1 |-> (tx_q > TX_W'(PASSIVE_LIMIT) || rx_count > 8'(PASSIVE_LIMIT))); // R6

  AST_TX_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    node_state != 2'd2 |-> tx_q <= TX_W'(BUSOFF_LIMIT)); // R7

  AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'd2 && !ev_idle_seq) |=> ($stable(tx_count_lo) && $stable(rx_count))); // R8

  AST_RECOVERY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busoff_q) |-> (tx_q == '0 && rx_count == 8'd0)); // R9
endmodule

// File: tb/can_fault_counters_test.sv
module can_fault_counters_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_err = 0, ev_rx_err_severe = 0, ev_rx_ok = 0;
  logic ev_tx_err = 0, ev_tx_ok = 0, ev_idle_seq = 0;
  logic [7:0] tx_count_lo, rx_count;
  logic [1:0] node_state;

  int checks = 0;
  int fails = 0;
  int m_tx, m_rx, m_rec;
  bit m_bo;

  always #10 clk = ~clk;

  can_fault_counters uut (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_err(ev_rx_err), .ev_rx_err_severe(ev_rx_err_severe), .ev_rx_ok(ev_rx_ok),
    .ev_tx_err(ev_tx_err), .ev_tx_ok(ev_tx_ok), .ev_idle_seq(ev_idle_seq),
    .tx_count_lo(tx_count_lo), .rx_count(rx_count), .node_state(node_state)
  );

  function automatic int tx_next(int tx, bit err, bit ok);
    if (err) return tx + 8;
    if (ok && tx > 0) return tx - 1;
    return tx;
  endfunction

  function automatic int rx_next(int rx, bit err, bit sev, bit ok);
    if (sev) return (rx + 8 > 255) ? 255 : rx + 8;
    if (err) return (rx + 1 > 255) ? 255 : rx + 1;
    if (ok) begin
      if (rx > 128) return 120;
      if (rx > 0) return rx - 1;
    end
    return rx;
  endfunction

  function automatic int state_of(int tx, int rx, bit bo);
    if (bo) return 2;
    if (tx > 127 || rx > 127) return 1;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "tx_count_lo", int'(tx_count_lo), m_tx & 255);
    check(tag, "rx_count", int'(rx_count), m_rx);
    check(tag, "node_state", int'(node_state), state_of(m_tx, m_rx, m_bo));
  endtask

  task automatic step(string tag, bit re, bit rs, bit ro, bit te, bit to, bit id);
    ev_rx_err = re; ev_rx_err_severe = rs; ev_rx_ok = ro;
    ev_tx_err = te; ev_tx_ok = to; ev_idle_seq = id;
    @(posedge clk);
    if (m_bo) begin
      if (id) begin
        if (m_rec == 127) begin m_tx = 0; m_rx = 0; m_rec = 0; m_bo = 0; end
        else m_rec++;
      end
    end else begin
      m_tx = tx_next(m_tx, te, to);
      m_rx = rx_next(m_rx, re, rs, ro);
      m_bo = m_tx > 255;
      m_rec = 0;
    end
    @(negedge clk);
    ev_rx_err = 0; ev_rx_err_severe = 0; ev_rx_ok = 0;
    ev_tx_err = 0; ev_tx_ok = 0; ev_idle_seq = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    m_tx = 0; m_rx = 0; m_rec = 0; m_bo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "tx_count_lo", int'(tx_count_lo), 0);
    check("R1", "rx_count", int'(rx_count), 0);
    check("R1", "node_state", int'(node_state), 0);

    step("R10 rx err beats ok", 1, 0, 1, 0, 0, 0);
    check("R10", "rx_count", int'(rx_count), 1);
    step("R3 severe", 0, 1, 0, 0, 0, 0);
    check("R3", "rx_count", int'(rx_count), 9);
    step("R3 both", 1, 1, 0, 0, 0, 0);
    check("R3", "rx_count", int'(rx_count), 17);
    for (int i = 0; i < 14; i++) step("R3 climb", 0, 1, 0, 0, 0, 0);
    check("R6", "node_state", int'(node_state), 1);
    step("R3 plus one", 1, 0, 0, 0, 0, 0);
    check("R4", "rx_count", int'(rx_count), 130);
    step("R4 reload", 0, 0, 1, 0, 0, 0);
    check("R4", "rx_count", int'(rx_count), 120);
    check("R6", "node_state", int'(node_state), 0);
    for (int i = 0; i < 121; i++) step("R4 drain", 0, 0, 1, 0, 0, 0);
    check("R4", "rx_count", int'(rx_count), 0);
    for (int i = 0; i < 16; i++) step("R4 to 128", 0, 1, 0, 0, 0, 0);
    step("R4 at 128", 0, 0, 1, 0, 0, 0);
    check("R4", "rx_count", int'(rx_count), 127);
    for (int i = 0; i < 20; i++) step("R5 saturate", 0, 1, 0, 0, 0, 0);
    check("R5", "rx_count", int'(rx_count), 255);
    step("R9 idle ignored when not bus-off", 0, 0, 0, 0, 0, 1);
    check("R9", "rx_count", int'(rx_count), 255);

    step("R2 tx ok at zero", 0, 0, 0, 0, 1, 0);
    check("R2", "tx_count_lo", int'(tx_count_lo), 0);
    for (int i = 0; i < 31; i++) step("R2 tx climb", 0, 0, 0, 1, 0, 0);
    check("R2", "tx_count_lo", int'(tx_count_lo), 248);
    check("R7", "node_state", int'(node_state), 1);
    step("R10 tx err beats ok", 0, 0, 0, 1, 1, 0);
    check("R7", "node_state", int'(node_state), 2);
    check("R2", "tx_count_lo low byte of 256", int'(tx_count_lo), 0);
    step("R8 ignore", 1, 1, 1, 1, 1, 0);
    step("R8 ignore", 0, 0, 1, 0, 1, 0);
    check("R8", "rx_count", int'(rx_count), 255);
    for (int i = 0; i < 127; i++) step("R9 idle", i[0], 0, 0, 0, i[1], 1);
    check("R9", "node_state before 128th", int'(node_state), 2);
    step("R9 128th idle", 0, 0, 0, 0, 0, 1);
    check("R9", "node_state", int'(node_state), 0);
    check("R9", "rx_count", int'(rx_count), 0);

    for (int ph = 0; ph < 12; ph++) begin
      int w_te, w_id;
      w_te = (ph % 3 == 0) ? 60 : 15;
      w_id = (ph % 3 == 2) ? 85 : 10;
      for (int i = 0; i < 600; i++) begin
        step("R2 R3 R4 R6 R7 R8 R9 R10 random",
             ($urandom % 100) < 25, ($urandom % 100) < 10, ($urandom % 100) < 40,
             ($urandom % 100) < w_te, ($urandom % 100) < 40, ($urandom % 100) < w_id);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule